// File: doc/BRIEF.md
# Eight-Pin Configurable GPIO Port Controller

This block is a general-purpose I/O port with eight pins, controlled through a small synchronous register bus. Each pin has six control bits: direction, output data, reduced drive, pull enable, polarity and interrupt enable. The block turns these bits into pad controls: output enable, output value, drive strength, pull-up and pull-down.

The polarity bit has two jobs. For an input pin with its pull enabled, it picks the pull direction. For a pin with its interrupt enabled, it picks the edge that raises the flag. Pad levels pass through a two-flop synchroniser before edge detection. Edges are detected on the pad level even when the pin drives as an output, so the port can watch its own driven level.

Each detected edge sets a sticky per-pin flag. The flags are cleared by writing 1. A single interrupt request combines the enabled flags. All reads are registered: the read data is valid one clock after the address is presented.

Top module: `pin_bank_ctrl`

## Requirements
- R1: Register map by address: 0 data, 1 direction, 2 reduced drive, 3 pull enable, 4 polarity, 5 interrupt enable, 6 flags, 7 reads as zero. Bit i of each register belongs to pin i. `pad_oe[i]` equals direction bit i, and `pad_out[i]` equals data bit i.
- R2: For an input pin (direction 0), pull enable 0 drives both `pad_pu` and `pad_pd` low. With pull enable 1, polarity 0 raises `pad_pu` and polarity 1 raises `pad_pd`.
- R3: For an output pin (direction 1), `pad_pu` and `pad_pd` are both 0, whatever the pull enable and polarity bits hold.
- R4: `pad_weak[i]` is 1 only when pin i is an output and its reduced-drive bit is 1. Reduced-drive bit 0 means full drive.
- R5: With interrupt enable 1, polarity 0 detects a falling pad edge and polarity 1 detects a rising pad edge. A pad change seen at clock edge k sets the flag at edge k+2. With interrupt enable 0, no flag is set.
- R6: Edge detection also runs when the pin is an output, using the pad level and the same polarity meaning.
- R7: Flags are sticky. Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged.
- R8: `irq` is the OR over all pins of the flag ANDed with its interrupt enable.
- R9: `rdata` is registered and shows the register addressed at the previous clock edge. A read of address 0 returns the synchronised pad level for input pins and the data bit for output pins.
- R10: After reset, all control bits and flags are 0. Every pin is then an input with no pull, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW (3) | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | NPINS (8) | Write data |
| rdata | output | NPINS (8) | Registered read data |
| pad_in | input | NPINS (8) | Pad levels, asynchronous |
| pad_oe | output | NPINS (8) | Pad output enable |
| pad_out | output | NPINS (8) | Pad output value |
| pad_weak | output | NPINS (8) | Reduced drive select |
| pad_pu | output | NPINS (8) | Pull-up enable |
| pad_pd | output | NPINS (8) | Pull-down enable |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight pins and a three-bit address. With these values, random register contents reach every mix of input and output pins in a single word, including mixed reads of address 0. Pad stimulus loops the driven level back to `pad_in` for output pins, so edges caused by the port's own drive reach the flags. The unused eighth address is then also reachable and can be checked to read as zero.

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl #(
  parameter int NPINS = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_weak,
  output logic [NPINS-1:0] pad_pu,
  output logic [NPINS-1:0] pad_pd,
  output logic             irq
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_RDRV = AW'(2);
  localparam logic [AW-1:0] A_PEN  = AW'(3);
  localparam logic [AW-1:0] A_POL  = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);
  localparam logic [AW-1:0] A_FLAG = AW'(6);

  logic [NPINS-1:0] data_q, dir_q, rdrv_q, pen_q, pol_q, ien_q, flag_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NPINS-1:0] det, clr_mask, rd_mux;

  assign pad_oe   = dir_q;
  assign pad_out  = data_q;
  assign pad_weak = dir_q & rdrv_q;
  assign pad_pu   = ~dir_q & pen_q & ~pol_q;
  assign pad_pd   = ~dir_q & pen_q & pol_q;

  assign det      = ien_q & ((pol_q & sync2_q & ~prev_q) | (~pol_q & ~sync2_q & prev_q));
  assign clr_mask = (wr_en && addr == A_FLAG) ? wdata : '0;
  assign irq      = |(flag_q & ien_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; dir_q <= '0; rdrv_q <= '0;
      pen_q  <= '0; pol_q <= '0; ien_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DATA: data_q <= wdata;
        A_DIR:  dir_q  <= wdata;
        A_RDRV: rdrv_q <= wdata;
        A_PEN:  pen_q  <= wdata;
        A_POL:  pol_q  <= wdata;
        A_IEN:  ien_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0; sync2_q <= '0; prev_q <= '0; flag_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
      flag_q  <= (flag_q & ~clr_mask) | det;
    end
  end

  always_comb begin
    case (addr)
      A_DATA:  rd_mux = (dir_q & data_q) | (~dir_q & sync2_q);
      A_DIR:   rd_mux = dir_q;
      A_RDRV:  rd_mux = rdrv_q;
      A_PEN:   rd_mux = pen_q;
      A_POL:   rd_mux = pol_q;
      A_IEN:   rd_mux = ien_q;
      A_FLAG:  rd_mux = flag_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end

  p_pull_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_pd) == '0);

  p_out_nopull_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_pu | pad_pd) & pad_oe) == '0);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flag_q & $past(flag_q & ~clr_mask)) == $past(flag_q & ~clr_mask)));

  p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_FLAG) |=> ((flag_q & $past(wdata & ~det)) == '0));

  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((det != '0) || (wr_en && addr == A_IEN)));

  p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (det != '0) |=> ((flag_q & $past(det)) == $past(det)));
endmodule

// File: tb/pin_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_bank_ctrl_tb_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = '0;
  logic [N-1:0] wdata = '0, ext = '0, rdata, pad_in;
  logic [N-1:0] pad_oe, pad_out, pad_weak, pad_pu, pad_pd;
  logic irq;
  int total = 0, bad = 0;
  logic [N-1:0] m_data = 0, m_dir = 0, m_rdrv = 0, m_pen = 0, m_pol = 0, m_ien = 0;

  always #2.5 clk = ~clk;
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext);

  pin_bank_ctrl dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_weak(pad_weak),
    .pad_pu(pad_pu), .pad_pd(pad_pd), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] exp_pads(input logic [N-1:0] dr, dt, rd, pe, pl);
    return {dr, dt, dr & rd, ~dr & pe & ~pl, ~dr & pe & pl};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
    case (a)
      3'd0: m_data = d; 3'd1: m_dir = d; 3'd2: m_rdrv = d;
      3'd3: m_pen = d;  3'd4: m_pol = d; 3'd5: m_ien = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk); addr = a; wr_en = 0;
    @(negedge clk); v = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd1234));
    idle(3); rst_n = 1; idle(3);
    // R10 reset state
    chk("R10 pads", {pad_oe, pad_out, pad_weak, pad_pu, pad_pd}, 40'h0);
    chk("R10 irq", irq, 0);
    for (int a = 0; a < 8; a++) begin rd(a[2:0], v); chk("R10 regs", v, 0); end

    // R1..R4 directed corner: output pins ignore pull bits
    wr(3'd3, 8'hFF); wr(3'd4, 8'h0F); wr(3'd1, 8'hF0); wr(3'd2, 8'hCC); wr(3'd0, 8'h5A);
    chk("R3 outputs no pull", {pad_pu, pad_pd}, {8'h00, 8'h0F});
    chk("R2 input pulls", {pad_pu, pad_pd}, {~m_dir & m_pen & ~m_pol, ~m_dir & m_pen & m_pol});
    chk("R4 weak", pad_weak, 8'hC0);
    chk("R1 oe/out", {pad_oe, pad_out}, {8'hF0, 8'h5A});

    // R1-style random config against model (R1 R2 R3 R4)
    for (int i = 0; i < 60; i++) begin
      logic [2:0] a; a = 3'($urandom_range(0, 5));
      wr(a, N'($urandom));
      chk("R1/R2/R3/R4 pads", {pad_oe, pad_out, pad_weak, pad_pu, pad_pd},
          exp_pads(m_dir, m_data, m_rdrv, m_pen, m_pol));
      rd(a, v);
      chk("R1 readback", v, a == 0 ? ((m_dir & m_data) | (~m_dir & ext)) :
          a == 1 ? m_dir : a == 2 ? m_rdrv : a == 3 ? m_pen : a == 4 ? m_pol : m_ien);
    end

    // R9 mixed data read
    wr(3'd1, 8'h0F); wr(3'd0, 8'hA5); ext = 8'h3C; idle(3);
    rd(3'd0, v); chk("R9 mixed read", v, 8'h35);
    rd(3'd7, v); chk("R1 addr7 zero", v, 0);

    // R5 timing: falling edge on pin 0, flag appears two edges after the sampling edge
    wr(3'd1, 8'h00); wr(3'd4, 8'h00); ext = 8'h01; idle(4);
    wr(3'd6, 8'hFF); wr(3'd5, 8'h01);
    ext = 8'h00; @(negedge clk); @(negedge clk);
    chk("R5 not yet", irq, 0);
    @(negedge clk); chk("R5 flag after sync", irq, 1);
    rd(3'd6, v); chk("R5 flag bit", v, 8'h01);
    // R7 write 0 keeps, write 1 clears
    wr(3'd6, 8'h00); rd(3'd6, v); chk("R7 write0 keeps", v, 8'h01);
    wr(3'd6, 8'h01); rd(3'd6, v); chk("R7 write1 clears", v, 8'h00);
    chk("R8 irq low after clear", irq, 0);

    // R5 random edges with model
    wr(3'd1, 8'h00);
    for (int i = 0; i < 40; i++) begin
      logic [N-1:0] p0, p1, e;
      p0 = N'($urandom); p1 = N'($urandom);
      wr(3'd4, N'($urandom)); wr(3'd5, N'($urandom));
      ext = p0; idle(4); wr(3'd6, 8'hFF);
      ext = p1; idle(4);
      e = m_ien & ((m_pol & ~p0 & p1) | (~m_pol & p0 & ~p1));
      rd(3'd6, v); chk("R5 random flags", v, e);
      chk("R8 irq", irq, |(e & m_ien));
      // R8 masking: disabling enables drops irq, flags stay
      wr(3'd5, 8'h00); chk("R8 masked", irq, 0);
      rd(3'd6, v); chk("R7 flags held", v, e);
    end

    // R6 edges in output mode from driven level
    wr(3'd5, 8'h00); wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd4, 8'hFF); ext = 8'hFF; idle(4);
    wr(3'd6, 8'hFF); wr(3'd5, 8'hFF);
    wr(3'd0, 8'hFF); idle(4);
    rd(3'd6, v); chk("R6 output rising", v, 8'hFF);
    wr(3'd6, 8'hFF); wr(3'd4, 8'h00); wr(3'd0, 8'h0F); idle(4);
    rd(3'd6, v); chk("R6 output falling", v, 8'hF0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule